// File: doc/BRIEF.md
# VIP Host Register-Access Bridge

This block lets a host processor run single register cycles on a video interface port (VIP) bus through a small memory-mapped window. The host first loads a target address word into the address register. That word carries the device select in bits 15:14, the port select in bits 13:12 and the register offset in the low bits. Bit 13 set marks a read and bit 13 clear marks a write. The host then moves data through the data register. A write to the data register after a write-type address starts a 4-byte write cycle on the downstream request/acknowledge port.

Reads are deferred. With the read-disable bit clear, a host read of the data register starts the downstream read and returns a value of no meaning. After busy drops, the host sets read-disable again. Later data-register reads then return the captured value, narrowed to the width of the triggering access, without starting a new cycle.

Each cycle has a watchdog counted in bus phases. A phase lasts (speed field + 1) clocks. The timeout is (timeout field + 1) phases. When the watchdog runs out, the cycle is aborted and a sticky flag is raised. The host must acknowledge that flag before any new cycle can start.

Top module: `vip_host_bridge`

## Requirements
- R1: After reset the control register (offset 0xC40) reads 0x000F000F: speed field bits 3:0 = 15, timeout field bits 19:16 = 15, busy bit 13 = 0. The status register (0xC50) reads 0x01000000: read-disable bit 24 = 1 and timeout flag bit 4 = 0. The data register (0x84) and the address register (0x80) read 0, and dn_req is 0.
- R2: A host write to 0x80 while idle stores bits 15:0 of the write data as the target address. A read of 0x80 returns it with bits 31:16 zero.
- R3: A host write to 0x84 while idle, with target-address bit 13 = 0 and the timeout flag clear, raises dn_req on the next cycle with dn_wr = 1, dn_size = 2 (4 bytes), dn_addr = target address and dn_wdata = the written data. Control bit 13 reads 1 from that cycle until the cycle after dn_ack is seen.
- R4: A host read of 0x84 while idle, with read-disable = 0, target-address bit 13 = 1 and the timeout flag clear, starts a read cycle with dn_wr = 0 and dn_size = hst_size. The size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R5: On dn_ack of a read cycle, dn_rdata narrowed to the cycle width (upper bits zero) is captured. The data register returns the captured value afterwards.
- R6: While read-disable = 1, a read of 0x84 starts no cycle and returns the captured value.
- R7: While a cycle is in progress, host writes to 0x80 and 0x84 are ignored. The target address, dn_addr and dn_wdata keep their values.
- R8: If no dn_ack arrives, the cycle is aborted exactly (T+1)*(S+1) clocks after it started, where S is the speed field and T is the timeout field. On abort dn_req and busy drop and status bit 4 is set.
- R9: Writing status with bit 4 = 1 clears the timeout flag, and with bit 4 = 0 leaves it unchanged. Bit 24 of the write always becomes the read-disable value.
- R10: While the timeout flag is set, data-register accesses start no cycle.
- R11: A dn_ack with no cycle outstanding changes no state; the captured value stays.
- R12: A data write with a read-type address, or a data read with a write-type address, starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 12 | Host byte offset of the accessed register |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access (side effects only) |
| hst_size | input | 2 | Host read width: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Register read data for hst_addr (combinational) |
| dn_req | output | 1 | Downstream cycle request, held until acknowledge or abort |
| dn_addr | output | 16 | Downstream target address |
| dn_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| dn_size | output | 2 | Downstream cycle width code |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Single-cycle acknowledge from the device |
| dn_rdata | input | 32 | Read data, valid with dn_ack |

## Verification
The bench builds the bridge with its default widths (16-bit target address, 4-bit speed and timeout fields). It then programs the control register at run time, so every speed and timeout value from 0 to 3 is swept. The abort clock count is checked against (T+1)*(S+1) for each pair. Read cycles are swept over all four device selects, both read-type port selects and all three widths, with the narrowed value computed arithmetically. The bench also covers device latencies of 0 to 3 clocks and the ignore cases: busy, read-disable, a pending timeout flag, a wrong-direction address and a stray acknowledge.

// File: rtl/vip_host_bridge.sv
module vip_host_bridge #(
  parameter int HAW   = 12,
  parameter int TAW   = 16,
  parameter int DW    = 32,
  parameter int SPD_W = 4,
  parameter int TMO_W = 4,
  parameter logic [SPD_W-1:0] SPD_RST = '1,
  parameter logic [TMO_W-1:0] TMO_RST = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HAW-1:0] hst_addr,
  input  logic           hst_wr,
  input  logic           hst_rd,
  input  logic [1:0]     hst_size,
  input  logic [DW-1:0]  hst_wdata,
  output logic [DW-1:0]  hst_rdata,
  output logic           dn_req,
  output logic [TAW-1:0] dn_addr,
  output logic           dn_wr,
  output logic [1:0]     dn_size,
  output logic [DW-1:0]  dn_wdata,
  input  logic           dn_ack,
  input  logic [DW-1:0]  dn_rdata
);

  localparam logic [HAW-1:0] OFS_ADDR = HAW'(12'h080);
  localparam logic [HAW-1:0] OFS_DATA = HAW'(12'h084);
  localparam logic [HAW-1:0] OFS_CTRL = HAW'(12'hC40);
  localparam logic [HAW-1:0] OFS_STS  = HAW'(12'hC50);
  localparam int RD_BIT   = 13;
  localparam int BUSY_BIT = 13;
  localparam int TMO_POS  = 16;
  localparam int FLAG_BIT = 4;
  localparam int RDIS_BIT = 24;
  localparam logic [TMO_W:0]   TMO_ONE = {{TMO_W{1'b0}}, 1'b1};
  localparam logic [SPD_W-1:0] SPD_ONE = {{(SPD_W-1){1'b0}}, 1'b1};

  logic [TAW-1:0]   tgt_addr;
  logic [DW-1:0]    cap;
  logic             busy, sts_tmo, rdis;
  logic [SPD_W-1:0] spd, ph_cnt;
  logic [TMO_W-1:0] tmo;
  logic [TMO_W:0]   tmo_cnt;
  logic             cyc_wr;
  logic [1:0]       cyc_size;
  logic [DW-1:0]    cyc_wdata;

  wire sel_addr = hst_addr == OFS_ADDR;
  wire sel_data = hst_addr == OFS_DATA;
  wire sel_ctrl = hst_addr == OFS_CTRL;
  wire sel_sts  = hst_addr == OFS_STS;

  wire can_go   = !busy && !sts_tmo;
  wire start_wr = hst_wr && sel_data && can_go && !tgt_addr[RD_BIT];
  wire start_rd = hst_rd && sel_data && can_go && !rdis && tgt_addr[RD_BIT];
  wire tick     = busy && (ph_cnt == spd);
  wire tmo_hit  = tick && (tmo_cnt == TMO_ONE);

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    narrow = v & {{(DW-8){1'b0}}, 8'hFF};
      2'd1:    narrow = v & {{(DW-16){1'b0}}, 16'hFFFF};
      default: narrow = v;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ph_cnt    <= '0;
      tmo_cnt   <= '0;
      cyc_wr    <= 1'b0;
      cyc_size  <= 2'd0;
      cyc_wdata <= '0;
      cap       <= '0;
    end else if (start_wr || start_rd) begin
      busy      <= 1'b1;
      ph_cnt    <= '0;
      tmo_cnt   <= {1'b0, tmo} + TMO_ONE;
      cyc_wr    <= start_wr;
      cyc_size  <= start_wr ? 2'd2 : hst_size;
      cyc_wdata <= start_wr ? hst_wdata : cyc_wdata;
    end else if (busy) begin
      if (dn_ack) begin
        busy <= 1'b0;
        if (!cyc_wr) cap <= narrow(dn_rdata, cyc_size);
      end else if (tmo_hit) begin
        busy <= 1'b0;
      end else begin
        ph_cnt <= tick ? '0 : ph_cnt + SPD_ONE;
        if (tick) tmo_cnt <= tmo_cnt - TMO_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      spd      <= SPD_RST;
      tmo      <= TMO_RST;
      rdis     <= 1'b1;
      sts_tmo  <= 1'b0;
    end else begin
      if (hst_wr && sel_addr && !busy) tgt_addr <= hst_wdata[TAW-1:0];
      if (hst_wr && sel_ctrl) begin
        spd <= hst_wdata[SPD_W-1:0];
        tmo <= hst_wdata[TMO_POS +: TMO_W];
      end
      if (hst_wr && sel_sts) rdis <= hst_wdata[RDIS_BIT];
      if (tmo_hit && !dn_ack) sts_tmo <= 1'b1;
      else if (hst_wr && sel_sts && hst_wdata[FLAG_BIT]) sts_tmo <= 1'b0;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (sel_addr) hst_rdata[TAW-1:0] = tgt_addr;
    if (sel_data) hst_rdata = cap;
    if (sel_ctrl) begin
      hst_rdata[SPD_W-1:0]         = spd;
      hst_rdata[TMO_POS +: TMO_W]  = tmo;
      hst_rdata[BUSY_BIT]          = busy;
    end
    if (sel_sts) begin
      hst_rdata[RDIS_BIT] = rdis;
      hst_rdata[FLAG_BIT] = sts_tmo;
    end
  end

  assign dn_req   = busy;
  assign dn_addr  = tgt_addr;
  assign dn_wr    = cyc_wr;
  assign dn_size  = cyc_size;
  assign dn_wdata = cyc_wdata;

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack && !tmo_hit) |=> (dn_req && $stable(dn_addr) && $stable(dn_wdata)));

  p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ack) |=> !dn_req);

  p_abort_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !dn_ack) |=> (sts_tmo && !dn_req));

  p_flag_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tmo && !dn_req) |=> !dn_req);

  p_req_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req) |-> ($past(dn_ack) || $past(tmo_hit)));

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_req && dn_ack) |=> $stable(cap));

endmodule

// File: tb/vip_host_bridge_tb_top.sv
`timescale 1ns/1ps
module vip_host_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] hst_addr = '0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [1:0]  hst_size = 2'd2;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        dn_req, dn_wr, dn_ack;
  logic [15:0] dn_addr;
  logic [1:0]  dn_size;
  logic [31:0] dn_wdata, dn_rdata;

  logic        dev_en = 1'b1;
  int          dev_lat = 0;
  int          dev_cnt = 0;
  logic        dev_ack = 1'b0;
  logic [31:0] dev_data = '0;
  logic        stray_ack = 1'b0;
  logic [31:0] stray_data = '0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vip_host_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_size(hst_size), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .dn_req(dn_req), .dn_addr(dn_addr), .dn_wr(dn_wr), .dn_size(dn_size),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata));

  assign dn_ack   = dev_ack | stray_ack;
  assign dn_rdata = stray_ack ? stray_data : dev_data;

  function automatic logic [31:0] dev_val(input logic [15:0] a);
    dev_val = {~a, a} ^ 32'h3C5A_96E1;
  endfunction

  always @(posedge clk) begin
    if (dev_ack) begin
      dev_ack <= 1'b0;
      dev_cnt <= 0;
    end else if (dn_req && dev_en) begin
      if (dev_cnt == dev_lat) begin
        dev_ack  <= 1'b1;
        dev_data <= dev_val(dn_addr);
      end else dev_cnt <= dev_cnt + 1;
    end else dev_cnt <= 0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic hwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hrd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    hst_addr = a; hst_size = sz; hst_rd = 1'b1;
    #1 v = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    hst_addr = a;
    #1 v = hst_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] c;
    n = 0;
    peek(12'hC40, c);
    while (c[13] && n < 5000) begin
      n++;
      @(negedge clk);
      peek(12'hC40, c);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, capv;
    logic [15:0] a;
    int n, bytes;
    repeat (3) @(negedge clk);
    // R1
    peek(12'hC40, v); chk("R1 ctrl", v, 32'h000F_000F);
    peek(12'hC50, v); chk("R1 status", v, 32'h0100_0000);
    peek(12'h084, v); chk("R1 data", v, 0);
    peek(12'h080, v); chk("R1 addr", v, 0);
    chk("R1 dn_req", {31'd0, dn_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    peek(12'hC40, v); chk("R1 ctrl after release", v, 32'h000F_000F);

    // R2
    hwr(12'h080, 32'hFFFF_C123);
    peek(12'h080, v); chk("R2 addr readback", v, 32'h0000_C123);

    // R3 write cycles with device latency 0..3
    for (int l = 0; l < 4; l++) begin
      dev_lat = l;
      a = 16'((l << 14) | (l << 12) | (16'h0F1 + l)) & 16'hDFFF;
      hwr(12'h080, {16'h0, a});
      hwr(12'h084, 32'hA5A5_0000 + l);
      chk("R3 dn_req", {31'd0, dn_req}, 1);
      chk("R3 dn_wr", {31'd0, dn_wr}, 1);
      chk("R3 dn_size", {30'd0, dn_size}, 2);
      chk("R3 dn_addr", {16'd0, dn_addr}, {16'd0, a});
      chk("R3 dn_wdata", dn_wdata, 32'hA5A5_0000 + l);
      busy_len(n);
      chk("R3 busy length", n, l + 2);
    end
    peek(12'hC50, v); chk("R3 no timeout flag", v, 32'h0100_0000);

    // R4 R5 R6 read sweep
    dev_lat = 1;
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 3; s++) begin
          a = 16'((d << 14) | (1 << 13) | (p << 12) | (16'h040 + 4 * s + d));
          hwr(12'h080, {16'h0, a});
          hwr(12'hC50, 32'h0);
          hrd(12'h084, 2'(s), v);
          chk("R4 dn_req", {31'd0, dn_req}, 1);
          chk("R4 dn_wr", {31'd0, dn_wr}, 0);
          chk("R4 dn_size", {30'd0, dn_size}, s);
          busy_len(n);
          hwr(12'hC50, 32'h0100_0000);
          bytes = (s == 0) ? 1 : (s == 1) ? 2 : 4;
          capv = 32'(64'(dev_val(a)) & ((64'd1 << (8 * bytes)) - 1));
          hrd(12'h084, 2'd2, v);
          chk("R5 captured narrowed", v, capv);
          chk("R6 no cycle while disabled", {31'd0, dn_req}, 0);
        end

    // R6 second read, same value
    hrd(12'h084, 2'd0, v);
    chk("R6 repeat read", v, capv);
    chk("R6 repeat no req", {31'd0, dn_req}, 0);

    // R12
    hwr(12'hC50, 32'h0);
    hwr(12'h084, 32'h1234_5678);
    chk("R12 write with read-type addr", {31'd0, dn_req}, 0);
    hwr(12'h080, 32'h0000_1111);
    hrd(12'h084, 2'd2, v);
    chk("R12 read with write-type addr", {31'd0, dn_req}, 0);
    peek(12'h084, v); chk("R12 capture kept", v, capv);
    hwr(12'hC50, 32'h0100_0000);

    // R7
    dev_lat = 6;
    hwr(12'h080, 32'h0000_4321);
    hwr(12'h084, 32'hDEAD_BEEF);
    hwr(12'h080, 32'h0000_0777);
    peek(12'h080, v); chk("R7 addr kept", v, 32'h0000_4321);
    chk("R7 dn_addr kept", {16'd0, dn_addr}, 32'h0000_4321);
    hwr(12'h084, 32'h0BAD_F00D);
    chk("R7 dn_wdata kept", dn_wdata, 32'hDEAD_BEEF);
    busy_len(n);

    // R11
    @(negedge clk);
    stray_data = 32'h7777_7777; stray_ack = 1'b1;
    @(negedge clk);
    stray_ack = 1'b0;
    peek(12'h084, v); chk("R11 stray ack ignored", v, capv);
    peek(12'hC40, v); chk("R11 still idle", {31'd0, v[13]}, 0);

    // R8 R9 R10 timeout sweep
    dev_en = 1'b0;
    for (int sp = 0; sp < 4; sp++)
      for (int t = 0; t < 4; t++) begin
        hwr(12'hC40, 32'((t << 16) | sp));
        hwr(12'h080, 32'h0000_8005);
        hwr(12'h084, 32'h0000_0055);
        busy_len(n);
        chk("R8 abort length", n, (t + 1) * (sp + 1));
        peek(12'hC50, v); chk("R8 flag set", v, 32'h0100_0010);
        chk("R8 dn_req low", {31'd0, dn_req}, 0);
        hwr(12'h084, 32'h0000_0066);
        chk("R10 no cycle with flag", {31'd0, dn_req}, 0);
        hwr(12'hC50, 32'h0100_0000);
        peek(12'hC50, v); chk("R9 zero keeps flag", v, 32'h0100_0010);
        hwr(12'hC50, 32'h0100_0010);
        peek(12'hC50, v); chk("R9 one clears flag", v, 32'h0100_0000);
      end
    hwr(12'hC50, 32'h0000_0000);
    peek(12'hC50, v); chk("R9 read-disable written low", v, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule